// File: doc/BRIEF.md
# DDR2 Refresh and Low-Power Sequencer

This block sits beside a DDR2 command scheduler and decides when the memory must be refreshed and when the clock-enable line may change. A free-running interval timer adds one owed refresh to a small backlog each period. The period is halved while the case-temperature flag is high. Whenever refreshes are owed, the block raises a request. It issues the auto-refresh strobe only once the scheduler reports that every bank is precharged. After each strobe it withholds command permission for the refresh recovery time. When the backlog reaches its ceiling, new traffic is held back until a refresh goes out.

On request the block drops CKE to enter self-refresh or power-down. A wake request raises CKE again. After a wake, separate hold-offs apply to non-read commands and to reads, and their lengths depend on the kind of sleep that is ending. CKE never changes level until it has been at its current level for a minimum number of cycles. After reset CKE is low. The block raises CKE by itself once that minimum has passed.

Top module: `dram_rfsh_seq`

## Requirements
- R1: While reset is asserted, `cke_o`, `cmd_ok_o`, `rd_ok_o` and `ref_cmd_o` are all 0.
- R2: After reset is released, CKE stays low for cycles 0 to 2 and goes high in cycle 3. Commands and reads are allowed from 2 cycles after that rise, which is cycle 5.
- R3: With the temperature flag low, one refresh becomes owed every 2600 cycles. The first one is visible in cycle 2600 after reset release. `rfsh_req_o` is 1 exactly while the backlog is non-zero.
- R4: The reload value of the interval timer is taken when the timer expires. With the temperature flag high at that moment, the next interval is 1300 cycles.
- R5: `ref_cmd_o` is a one-cycle strobe. It is asserted only in a cycle where CKE is high, a refresh is owed, `banks_idle_i` is 1 and no hold-off is running. Until then the request stays asserted and no strobe appears.
- R6: In the strobe cycle and the 34 cycles after it, `cmd_ok_o` and `rd_ok_o` are 0 and no further strobe is issued. This makes the recovery time 35 cycles.
- R7: The backlog saturates at 8. While it is 8, `cmd_ok_o` and `rd_ok_o` are 0, and back-to-back refreshes drain exactly 8.
- R8: If `sr_req_i` and `banks_idle_i` are both 1 while commands are allowed, CKE falls in the next cycle. `cmd_ok_o` is 0 in the entry cycle. Self-refresh clears the backlog and issues no strobe. On exit the interval timer restarts with a full period.
- R9: Counting from the cycle CKE rises after self-refresh, non-read commands are allowed after 39 cycles and reads after 200 cycles.
- R10: CKE keeps each level for at least 3 cycles before it may change.
- R11: A power-down entered with `banks_idle_i` = 1 (precharge power-down) allows both commands and reads 2 cycles after CKE rises. The refresh timer keeps running during power-down.
- R12: A power-down entered with banks open (active power-down) allows non-read commands 2 cycles after CKE rises. Reads wait 2 cycles when `slow_exit_i` = 0, and 7 minus `add_lat_i` cycles (at least 1) when `slow_exit_i` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hot_i | input | 1 | Case temperature above the normal range; halves the refresh period |
| banks_idle_i | input | 1 | All banks are precharged |
| sr_req_i | input | 1 | Request to enter self-refresh |
| pd_req_i | input | 1 | Request to enter power-down |
| wake_i | input | 1 | Request to leave self-refresh or power-down |
| slow_exit_i | input | 1 | Active power-down uses the slow exit timing |
| add_lat_i | input | 3 | Additive latency in cycles, used for the slow exit |
| cke_o | output | 1 | Clock enable to the memory |
| ref_cmd_o | output | 1 | Issue one auto-refresh command this cycle |
| rfsh_req_o | output | 1 | At least one refresh is owed |
| cmd_ok_o | output | 1 | Scheduler may issue a non-read command this cycle |
| rd_ok_o | output | 1 | Scheduler may issue a read this cycle |

## Verification
Most internal faults show up at the ports within one refresh period. A wrong interval reload or backlog count moves the strobe schedule, and the scoreboard compares that schedule cycle for cycle. A faulty saturation adds a ninth strobe to the drain burst. A wrong hold-off value or exit selection moves the rising edge of `cmd_ok_o` or `rd_ok_o` by at least one cycle. Each of those edges is sampled on both sides of the cycle where it should occur. A CKE dwell fault shows as an early CKE edge right after a sleep entry or at boot.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

  typedef enum logic [1:0] {
    PS_RUN  = 2'd0,
    PS_SELF = 2'd1,
    PS_PDN  = 2'd2
  } pwr_state_e;

  // Refresh period chosen at timer reload.
  function automatic int unsigned pick_refi(input logic hot,
                                            input int unsigned norm,
                                            input int unsigned warm);
    return hot ? warm : norm;
  endfunction

  // Read hold-off after active power-down exit.
  function automatic int unsigned rd_exit_wait(input logic slow,
                                               input int unsigned al,
                                               input int unsigned fast,
                                               input int unsigned slow_base);
    if (!slow) return fast;
    if (al + 1 >= slow_base) return 1;
    return slow_base - al;
  endfunction

  function automatic int unsigned max_of(input int unsigned a,
                                         input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rfsh_timer.sv
module rfsh_timer
  import rfsh_pkg::*;
#(
  parameter int unsigned REFI_NORM = 2600,
  parameter int unsigned REFI_HOT  = 1300,
  parameter int unsigned MAX_DEBT  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hot_i,
  input  logic freeze_i,
  input  logic flush_i,
  input  logic issue_i,
  output logic pending_o,
  output logic full_o
);
  localparam int TW = $clog2(REFI_NORM + 1);
  localparam int DW = $clog2(MAX_DEBT + 1);

  logic [TW-1:0] tmr_q;
  logic [DW-1:0] debt_q;
  logic          tick;

  assign tick = !freeze_i && (tmr_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      tmr_q <= TW'(REFI_NORM - 1);
    else if (freeze_i || tmr_q == '0)
      tmr_q <= TW'(pick_refi(hot_i, REFI_NORM, REFI_HOT) - 1);
    else
      tmr_q <= tmr_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      debt_q <= '0;
    else if (flush_i)
      debt_q <= '0;
    else if (tick && !issue_i && debt_q != DW'(MAX_DEBT))
      debt_q <= debt_q + 1'b1;
    else if (issue_i && !tick)
      debt_q <= debt_q - 1'b1;
  end

  assign pending_o = (debt_q != '0);
  assign full_o    = (debt_q == DW'(MAX_DEBT));

  AST_DEBT_CAP: assert property (@(posedge clk) disable iff (!rst_n) debt_q <= DW'(MAX_DEBT)); // R7
  AST_ISSUE_OWED: assert property (@(posedge clk) disable iff (!rst_n) issue_i |-> debt_q != '0); // R5
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n) flush_i |=> !pending_o); // R8

endmodule

// File: rtl/rfsh_hold.sv
module rfsh_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (load_i)
      cnt_q <= val_i;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/cke_dwell.sv
module cke_dwell #(
  parameter int unsigned CKE_MIN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cke_now_i,
  input  logic cke_next_i,
  output logic ok_o
);
  localparam int CW = $clog2(CKE_MIN + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= CW'(1);
    else if (cke_next_i != cke_now_i)
      cnt_q <= CW'(1);
    else if (cnt_q < CW'(CKE_MIN))
      cnt_q <= cnt_q + 1'b1;
  end

  assign ok_o = (cnt_q >= CW'(CKE_MIN));

endmodule

// File: rtl/dram_rfsh_seq.sv
module dram_rfsh_seq
  import rfsh_pkg::*;
#(
  parameter int unsigned REFI_NORM = 2600,
  parameter int unsigned REFI_HOT  = 1300,
  parameter int unsigned T_RFC     = 35,
  parameter int unsigned T_XSNR    = 39,
  parameter int unsigned T_XSRD    = 200,
  parameter int unsigned T_XP      = 2,
  parameter int unsigned T_XARD    = 2,
  parameter int unsigned T_XARDS   = 7,
  parameter int unsigned CKE_MIN   = 3,
  parameter int unsigned MAX_DEBT  = 8,
  parameter int          AL_W      = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hot_i,
  input  logic            banks_idle_i,
  input  logic            sr_req_i,
  input  logic            pd_req_i,
  input  logic            wake_i,
  input  logic            slow_exit_i,
  input  logic [AL_W-1:0] add_lat_i,
  output logic            cke_o,
  output logic            ref_cmd_o,
  output logic            rfsh_req_o,
  output logic            cmd_ok_o,
  output logic            rd_ok_o
);
  localparam int unsigned HOLD_TOP = max_of(max_of(T_RFC, T_XSNR), max_of(T_XSRD, T_XARDS));
  localparam int HW = $clog2(HOLD_TOP + 1);

  pwr_state_e state_q, st_d;
  logic       pd_active_q, boot_q;
  logic       in_run, debt_pend, debt_full, dwell_ok;
  logic       ev_issue, ev_enter_sr, ev_enter_pd, ev_exit, ev_load;
  logic       any_zero, rd_zero;
  logic [HW-1:0] hval [2];
  logic          hzero [2];

  assign in_run = (state_q == PS_RUN);

  // Named events used by the assertions.
  assign ev_issue    = in_run && debt_pend && banks_idle_i && any_zero;
  assign ev_enter_sr = in_run && !ev_issue && sr_req_i && banks_idle_i && any_zero && dwell_ok;
  assign ev_enter_pd = in_run && !ev_issue && !sr_req_i && pd_req_i && !debt_full
                       && any_zero && dwell_ok;
  assign ev_exit     = !in_run && dwell_ok && (wake_i || boot_q);
  assign ev_load     = ev_issue || ev_exit;

  always_comb begin
    st_d = state_q;
    if (ev_enter_sr)      st_d = PS_SELF;
    else if (ev_enter_pd) st_d = PS_PDN;
    else if (ev_exit)     st_d = PS_RUN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= PS_PDN;
      pd_active_q <= 1'b0;
      boot_q      <= 1'b1;
    end else begin
      state_q <= st_d;
      if (ev_enter_pd) pd_active_q <= !banks_idle_i;
      if (ev_exit)     boot_q      <= 1'b0;
    end
  end

  // Hold-off lengths: index 0 gates every command, index 1 gates reads.
  always_comb begin
    hval[0] = HW'(T_XP);
    hval[1] = HW'(T_XP);
    if (ev_issue) begin
      hval[0] = HW'(T_RFC - 1);
      hval[1] = HW'(T_RFC - 1);
    end else if (state_q == PS_SELF) begin
      hval[0] = HW'(T_XSNR);
      hval[1] = HW'(T_XSRD);
    end else if (pd_active_q) begin
      hval[1] = HW'(rd_exit_wait(slow_exit_i, int'(unsigned'(add_lat_i)), T_XARD, T_XARDS));
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_hold
    rfsh_hold #(.W(HW)) u_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (ev_load),
      .val_i  (hval[g]),
      .zero_o (hzero[g])
    );
  end
  assign any_zero = hzero[0];
  assign rd_zero  = hzero[1];

  rfsh_timer #(
    .REFI_NORM (REFI_NORM),
    .REFI_HOT  (REFI_HOT),
    .MAX_DEBT  (MAX_DEBT)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .hot_i     (hot_i),
    .freeze_i  (state_q == PS_SELF),
    .flush_i   (ev_enter_sr),
    .issue_i   (ev_issue),
    .pending_o (debt_pend),
    .full_o    (debt_full)
  );

  cke_dwell #(.CKE_MIN(CKE_MIN)) u_dwell (
    .clk        (clk),
    .rst_n      (rst_n),
    .cke_now_i  (in_run),
    .cke_next_i (st_d == PS_RUN),
    .ok_o       (dwell_ok)
  );

  assign cke_o      = in_run;
  assign ref_cmd_o  = ev_issue;
  assign rfsh_req_o = debt_pend;
  assign cmd_ok_o   = in_run && any_zero && !debt_full && !ev_issue && !ev_enter_sr && !ev_enter_pd;
  assign rd_ok_o    = in_run && rd_zero  && !debt_full && !ev_issue && !ev_enter_sr && !ev_enter_pd;

  AST_REF_HAS_DEBT: assert property (@(posedge clk) disable iff (!rst_n) ref_cmd_o |-> rfsh_req_o && banks_idle_i); // R5
  AST_RFC_BLOCK: assert property (@(posedge clk) disable iff (!rst_n) ref_cmd_o |=> !cmd_ok_o && !rd_ok_o && !ref_cmd_o); // R6
  AST_CKE_DWELL: assert property (@(posedge clk) disable iff (!rst_n) !$stable(cke_o) |-> $past(dwell_ok)); // R10
  AST_NO_REF_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n) !cke_o |-> !ref_cmd_o && !cmd_ok_o); // R8
  AST_URGENT_GATE: assert property (@(posedge clk) disable iff (!rst_n) debt_full |-> !cmd_ok_o && !rd_ok_o); // R7
  AST_WAKE_GATE: assert property (@(posedge clk) disable iff (!rst_n) $rose(cke_o) |-> !cmd_ok_o && !rd_ok_o); // R9

endmodule

// File: tb/dram_rfsh_seq_bench.sv
module dram_rfsh_seq_bench;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hot_i = 1'b0, banks_idle_i = 1'b1, sr_req_i = 1'b0, pd_req_i = 1'b0;
  logic wake_i = 1'b0, slow_exit_i = 1'b0;
  logic [2:0] add_lat_i = 3'd0;
  logic cke_o, ref_cmd_o, rfsh_req_o, cmd_ok_o, rd_ok_o;

  int unsigned cyc = 0;
  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;
  int unsigned exp_ref[$];
  string       exp_tag[$];

  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  dram_rfsh_seq u_dram_rfsh_seq (
    .clk(clk), .rst_n(rst_n), .hot_i(hot_i), .banks_idle_i(banks_idle_i),
    .sr_req_i(sr_req_i), .pd_req_i(pd_req_i), .wake_i(wake_i),
    .slow_exit_i(slow_exit_i), .add_lat_i(add_lat_i),
    .cke_o(cke_o), .ref_cmd_o(ref_cmd_o), .rfsh_req_o(rfsh_req_o),
    .cmd_ok_o(cmd_ok_o), .rd_ok_o(rd_ok_o)
  );

  task automatic push_ref(input int unsigned c, input string tag);
    exp_ref.push_back(c);
    exp_tag.push_back(tag);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s cyc=%0d actual=%b expected=%b", req, what, cyc, act, exp);
    end
  endtask

  // Advance to the drive point of cycle n.
  task automatic go(input int unsigned n);
    while (cyc < n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic smp();
    @(negedge clk);
  endtask

  // Scoreboard monitor: every strobe must match the next expected cycle.
  always @(negedge clk) begin
    if (rst_n && ref_cmd_o) begin
      n_vec++;
      if (exp_ref.size() == 0) begin
        n_bad++;
        $display("FAIL R5 unexpected refresh cyc=%0d actual=strobe expected=none", cyc);
      end else begin
        automatic int unsigned e = exp_ref.pop_front();
        automatic string t = exp_tag.pop_front();
        if (e != cyc) begin
          n_bad++;
          $display("FAIL %s refresh actual cyc=%0d expected cyc=%0d", t, cyc, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    push_ref(2600, "R3");
    push_ref(5200, "R3");
    for (int i = 0; i < 8; i++) push_ref(28610 + 35*i, "R7");
    push_ref(29900, "R4");
    push_ref(31200, "R4");
    push_ref(32604, "R8");
    push_ref(33904, "R11");
    push_ref(35300, "R5");

    repeat (3) @(posedge clk);
    smp();
    chk("R1", "cke", cke_o, 1'b0);
    chk("R1", "cmd_ok", cmd_ok_o, 1'b0);
    chk("R1", "rd_ok", rd_ok_o, 1'b0);
    chk("R1", "ref", ref_cmd_o, 1'b0);
    @(posedge clk); #1 rst_n = 1'b1;

    go(2);  smp(); chk("R10", "cke boot", cke_o, 1'b0);
    go(3);  smp(); chk("R2", "cke rise", cke_o, 1'b1);
    go(4);  smp(); chk("R2", "cmd_ok", cmd_ok_o, 1'b0);
    go(5);  smp(); chk("R2", "cmd_ok", cmd_ok_o, 1'b1); chk("R2", "rd_ok", rd_ok_o, 1'b1);

    go(2599); smp(); chk("R3", "req", rfsh_req_o, 1'b0);
    go(2600); smp(); chk("R3", "req", rfsh_req_o, 1'b1);
    go(2634); smp(); chk("R6", "cmd_ok", cmd_ok_o, 1'b0); chk("R6", "rd_ok", rd_ok_o, 1'b0);
    go(2635); smp(); chk("R6", "cmd_ok", cmd_ok_o, 1'b1); chk("R3", "req", rfsh_req_o, 1'b0);

    go(5300); banks_idle_i = 1'b0;
    go(7799); smp(); chk("R3", "req", rfsh_req_o, 1'b0);
    go(7800); smp(); chk("R5", "req held", rfsh_req_o, 1'b1); chk("R5", "ref busy", ref_cmd_o, 1'b0);
    go(25999); smp(); chk("R7", "cmd_ok", cmd_ok_o, 1'b1);
    go(26000); smp(); chk("R7", "cmd_ok", cmd_ok_o, 1'b0); chk("R7", "rd_ok", rd_ok_o, 1'b0);
    go(27000); hot_i = 1'b1;
    go(28610); banks_idle_i = 1'b1;
    go(28856); smp(); chk("R7", "drained", rfsh_req_o, 1'b0);

    go(31300); sr_req_i = 1'b1; smp(); chk("R8", "cmd_ok entry", cmd_ok_o, 1'b0);
    go(31301); sr_req_i = 1'b0; smp(); chk("R8", "cke", cke_o, 1'b0);
    go(31302); wake_i = 1'b1; smp(); chk("R10", "cke", cke_o, 1'b0);
    go(31303); smp(); chk("R10", "cke", cke_o, 1'b0);
    go(31304); wake_i = 1'b0; smp(); chk("R10", "cke", cke_o, 1'b1);
    go(31342); smp(); chk("R9", "cmd_ok", cmd_ok_o, 1'b0);
    go(31343); smp(); chk("R9", "cmd_ok", cmd_ok_o, 1'b1); chk("R9", "rd_ok", rd_ok_o, 1'b0);
    go(31503); smp(); chk("R9", "rd_ok", rd_ok_o, 1'b0);
    go(31504); smp(); chk("R9", "rd_ok", rd_ok_o, 1'b1);

    go(32700); pd_req_i = 1'b1;
    go(32701); pd_req_i = 1'b0; smp(); chk("R11", "cke", cke_o, 1'b0);
    go(32710); wake_i = 1'b1;
    go(32711); wake_i = 1'b0; smp(); chk("R11", "cke", cke_o, 1'b1);
    go(32712); smp(); chk("R11", "cmd_ok", cmd_ok_o, 1'b0); chk("R11", "rd_ok", rd_ok_o, 1'b0);
    go(32713); smp(); chk("R11", "cmd_ok", cmd_ok_o, 1'b1); chk("R11", "rd_ok", rd_ok_o, 1'b1);

    go(33950); banks_idle_i = 1'b0;
    go(34000); pd_req_i = 1'b1;
    go(34001); pd_req_i = 1'b0; smp(); chk("R12", "cke", cke_o, 1'b0);
    go(34010); wake_i = 1'b1;
    go(34011); wake_i = 1'b0;
    go(34012); smp(); chk("R12", "rd_ok fast", rd_ok_o, 1'b0);
    go(34013); smp(); chk("R12", "rd_ok fast", rd_ok_o, 1'b1); chk("R12", "cmd_ok", cmd_ok_o, 1'b1);
    go(34050); slow_exit_i = 1'b1; add_lat_i = 3'd1;
    go(34100); pd_req_i = 1'b1;
    go(34101); pd_req_i = 1'b0;
    go(34110); wake_i = 1'b1;
    go(34111); wake_i = 1'b0;
    go(34113); smp(); chk("R12", "cmd_ok slow", cmd_ok_o, 1'b1); chk("R12", "rd_ok slow", rd_ok_o, 1'b0);
    go(34116); smp(); chk("R12", "rd_ok slow", rd_ok_o, 1'b0);
    go(34117); smp(); chk("R12", "rd_ok slow", rd_ok_o, 1'b1);

    go(35250); smp(); chk("R5", "req held", rfsh_req_o, 1'b1); chk("R5", "ref busy", ref_cmd_o, 1'b0);
    go(35300); banks_idle_i = 1'b1;
    go(35400); smp();
    n_vec++;
    if (exp_ref.size() != 0) begin
      n_bad++;
      $display("FAIL R3 missing refreshes actual=%0d left expected=0", exp_ref.size());
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule